// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block reads conversion results from a serial analog-to-digital converter that has only three wires: an active-low chip select, a serial clock and a data-out line. The block drives chip select and the serial clock and listens on data-out. It runs on a fast system clock and derives from it a serial clock whose half-period is a whole number of system cycles. One frame runs for each start request. A free-run input makes frames follow each other with no request.

Every frame begins with four zero bits from the converter, then the result, most significant bit first. The result is 8, 10 or 12 bits wide, chosen by a parameter. The block checks that the four leading bits are really zero. It returns the result as a parallel word together with a one-cycle strobe. If a leading bit is not zero, it reports an error instead of a result. Between frames it holds chip select high for a minimum quiet time. A request that arrives while a frame or a quiet time is running is kept until it can be served.

Parameters fix the system clock rate, the divider and the allowed serial-clock range. A divider that would put the serial clock outside that range stops elaboration. So does an unsupported resolution.

Top module: `sadc_capture`

## Requirements
- R1: The serial clock idles high. Whenever chip select is high, the serial clock is high too.
- R2: Within a frame, every serial-clock level and the chip-select-low lead time last exactly DIV_HALF system cycles. The same holds for the time from the last rising serial-clock edge to chip select rising.
- R3: A frame keeps chip select low for exactly (2·RES_BITS+7)·DIV_HALF system cycles and gives exactly RES_BITS+3 falling serial-clock edges.
- R4: Leading bit 1 is sampled just before the first falling edge, and leading bits 2 to 4 on rising edges 1 to 3. The result bits are sampled on rising edges 4 to RES_BITS+3, most significant bit first. They are presented as straight binary on result_o, and result_o[RES_BITS-1] carries the first result bit received.
- R5: valid_o is high for exactly one system cycle. That cycle is the first one in which cs_n_o reads high after a good frame, and result_o takes the new value in the same cycle. result_o changes at no other time.
- R6: If any leading bit samples as 1, pre_err_o pulses for one cycle in place of valid_o, and result_o keeps its previous value.
- R7: Between two frames chip select stays high for at least 2·GAP_SCK·DIV_HALF system cycles. With the defaults this is 2 serial-clock periods. A frame that follows at once sees exactly 2·GAP_SCK·DIV_HALF+1 cycles high.
- R8: A start request during a frame or during the quiet time is held and served after the quiet time. Several such requests give only one extra frame.
- R9: While free_run_i is high, frames repeat with a period of (2·RES_BITS+7+2·GAP_SCK)·DIV_HALF+1 system cycles. Once it is low and no request is pending, no new frame begins.
- R10: When the block is idle, cs_n_o goes low on the first clock edge at which start_i is seen high.
- R11: The codes 0 and 2^RES_BITS−1 pass through unchanged, with no clipping or offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| free_run_i | input | 1 | Run frames back to back while high |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sck_o | output | 1 | Serial clock to the converter, idles high |
| result_o | output | RES_BITS | Last good conversion result |
| valid_o | output | 1 | One-cycle strobe: result_o has a new result |
| pre_err_o | output | 1 | One-cycle strobe: a leading bit was not zero |

## Verification
The bench sweeps every 8-bit code through the converter model, including the all-zero and full-scale codes. A design that dropped the first result bit or reversed the bit order would return wrong codes. One that sampled a cycle early would shift the word by one bit. Each of the four leading-bit positions gets a 1 in turn. A design that skipped the first one, which is read before any clock edge, or that updated the word on an error would fail there. Requests sent during a frame and during the quiet time, and free-run mode, expose a controller that drops held requests, starts a second frame per request, or shortens the quiet time.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_GAP   = 2'd2
   } sadc_phase_e;

   localparam int unsigned LEAD_ZEROS = 4;

   // half-period ticks from chip select low to chip select high
   function automatic int unsigned frame_ticks(input int unsigned res);
      return 2 * (res + LEAD_ZEROS - 1) + 1;
   endfunction

   function automatic bit res_supported(input int unsigned res);
      return (res == 8) || (res == 10) || (res == 12);
   endfunction

endpackage

// File: rtl/sadc_tick_gen.sv
module sadc_tick_gen #(
   parameter int unsigned DIV_HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIV_HALF == 1) begin : g_every_cycle
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign tick = run;
      end else begin : g_counter
         localparam int unsigned CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] TOP = CW'(DIV_HALF - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || tick) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = run && (cnt == TOP);
      end
   endgenerate

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
   import sadc_pkg::*;
#(
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned GAP_SCK  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_i,
   input  logic free_run_i,
   output logic run,
   output logic cs_n,
   output logic sck,
   output logic pre_smp,
   output logic dat_smp,
   output logic fin
);

   localparam int unsigned LAST_T = frame_ticks(RES_BITS);
   localparam int unsigned GAP_T  = 2 * GAP_SCK;
   localparam int unsigned TMAX   = (LAST_T > GAP_T) ? LAST_T : GAP_T;
   localparam int unsigned TW     = $clog2(TMAX + 1);

   localparam logic [TW-1:0] T_FIRST     = TW'(1);
   localparam logic [TW-1:0] T_PRE_END   = TW'(2 * (LEAD_ZEROS - 1));
   localparam logic [TW-1:0] T_DAT_BEG   = TW'(2 * LEAD_ZEROS);
   localparam logic [TW-1:0] T_LAST_RISE = TW'(LAST_T - 1);
   localparam logic [TW-1:0] T_LAST      = TW'(LAST_T);
   localparam logic [TW-1:0] T_GAP       = TW'(GAP_T);

   sadc_phase_e   phase;
   logic [TW-1:0] tcnt;
   logic [TW-1:0] t_next;
   logic          pend;
   logic          in_frame;
   logic          rising;

   assign t_next   = tcnt + 1'b1;
   assign in_frame = (phase == PH_FRAME);
   assign rising   = !t_next[0];
   assign run      = (phase != PH_IDLE);

   // R4: leading bit 1 before the first fall, bits 2..4 on rises 1..3
   assign pre_smp = tick && in_frame &&
                    ((t_next == T_FIRST) || (rising && (t_next <= T_PRE_END)));
   assign dat_smp = tick && in_frame && rising &&
                    (t_next >= T_DAT_BEG) && (t_next <= T_LAST_RISE);
   assign fin     = tick && in_frame && (t_next == T_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tcnt  <= '0;
         cs_n  <= 1'b1;
         sck   <= 1'b1;
         pend  <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start_i || pend || free_run_i) begin
                  phase <= PH_FRAME;
                  cs_n  <= 1'b0;
                  tcnt  <= '0;
                  pend  <= 1'b0;
               end
            end
            PH_FRAME: begin
               if (start_i) pend <= 1'b1;
               if (tick) begin
                  if (t_next == T_LAST) begin
                     cs_n  <= 1'b1;
                     phase <= PH_GAP;
                     tcnt  <= '0;
                  end else begin
                     tcnt <= t_next;
                     sck  <= rising;
                  end
               end
            end
            PH_GAP: begin
               if (start_i) pend <= 1'b1;
               if (tick) begin
                  if (t_next == T_GAP) begin
                     phase <= PH_IDLE;
                     tcnt  <= '0;
                  end else begin
                     tcnt <= t_next;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sadc_shreg.sv
module sadc_shreg #(
   parameter int unsigned RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sdo_i,
   input  logic                pre_smp,
   input  logic                dat_smp,
   input  logic                fin,
   output logic [RES_BITS-1:0] result,
   output logic                valid,
   output logic                pre_err
);

   logic [RES_BITS-1:0] sh;
   logic                bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bad     <= 1'b0;
         result  <= '0;
         valid   <= 1'b0;
         pre_err <= 1'b0;
      end else begin
         valid   <= 1'b0;
         pre_err <= 1'b0;
         if (pre_smp) bad <= bad | sdo_i;
         if (dat_smp) sh <= {sh[RES_BITS-2:0], sdo_i};
         if (fin) begin
            bad <= 1'b0;
            if (bad) begin
               pre_err <= 1'b1;          // R6
            end else begin
               valid  <= 1'b1;           // R5
               result <= sh;
            end
         end
      end
   end

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
   import sadc_pkg::*;
#(
   parameter int unsigned SYS_CLK_HZ = 50_000_000,
   parameter int unsigned DIV_HALF   = 10,
   parameter int unsigned RES_BITS   = 12,
   parameter int unsigned GAP_SCK    = 2,
   parameter int unsigned SCK_MIN_HZ = 150_000,
   parameter int unsigned SCK_MAX_HZ = 3_400_000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                free_run_i,
   input  logic                sdo_i,
   output logic                cs_n_o,
   output logic                sck_o,
   output logic [RES_BITS-1:0] result_o,
   output logic                valid_o,
   output logic                pre_err_o
);

   localparam int unsigned SCK_HZ = SYS_CLK_HZ / (2 * DIV_HALF);

   generate
      if (!res_supported(RES_BITS)) begin : g_bad_res
         $error("sadc_capture: RES_BITS must be 8, 10 or 12");
      end
      if ((SCK_HZ < SCK_MIN_HZ) || (SCK_HZ > SCK_MAX_HZ)) begin : g_bad_sck
         $error("sadc_capture: DIV_HALF puts the serial clock outside its window");
      end
      if (GAP_SCK < 2) begin : g_bad_gap
         $error("sadc_capture: GAP_SCK must be at least 2");
      end
   endgenerate

   logic run;
   logic tick;
   logic pre_smp;
   logic dat_smp;
   logic fin;

   sadc_tick_gen #(
      .DIV_HALF (DIV_HALF)
   ) i_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   sadc_seq #(
      .RES_BITS (RES_BITS),
      .GAP_SCK  (GAP_SCK)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start_i    (start_i),
      .free_run_i (free_run_i),
      .run        (run),
      .cs_n       (cs_n_o),
      .sck        (sck_o),
      .pre_smp    (pre_smp),
      .dat_smp    (dat_smp),
      .fin        (fin)
   );

   sadc_shreg #(
      .RES_BITS (RES_BITS)
   ) i_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sdo_i   (sdo_i),
      .pre_smp (pre_smp),
      .dat_smp (dat_smp),
      .fin     (fin),
      .result  (result_o),
      .valid   (valid_o),
      .pre_err (pre_err_o)
   );

endmodule

// File: rtl/sadc_capture_chk.sv
module sadc_capture_chk #(
   parameter int unsigned DIV_HALF = 10,
   parameter int unsigned RES_BITS = 12,
   parameter int unsigned GAP_SCK  = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n_o,
   input logic                sck_o,
   input logic [RES_BITS-1:0] result_o,
   input logic                valid_o,
   input logic                pre_err_o
);

   localparam int unsigned CW = 20;
   localparam logic [CW-1:0] HALF_V  = CW'(DIV_HALF);
   localparam logic [CW-1:0] FRAME_V = CW'((2 * RES_BITS + 7) * DIV_HALF);
   localparam logic [CW-1:0] GAP_V   = CW'(2 * GAP_SCK * DIV_HALF);
   localparam logic [7:0]    FALLS_V = 8'(RES_BITS + 3);

   logic          prev_cs;
   logic          prev_sck;
   logic [CW-1:0] since;
   logic [CW-1:0] lo_run;
   logic [CW-1:0] hi_run;
   logic [7:0]    falls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs  <= 1'b1;
         prev_sck <= 1'b1;
         since    <= '0;
         lo_run   <= '0;
         hi_run   <= '1;
         falls    <= '0;
      end else begin
         prev_cs  <= cs_n_o;
         prev_sck <= sck_o;
         if ((cs_n_o != prev_cs) || (sck_o != prev_sck)) since <= CW'(1);
         else if (since != '1) since <= since + 1'b1;
         if (cs_n_o) lo_run <= '0;
         else        lo_run <= lo_run + 1'b1;
         if (!cs_n_o)            hi_run <= '0;
         else if (hi_run != '1)  hi_run <= hi_run + 1'b1;
         if (cs_n_o)                        falls <= '0;
         else if (prev_sck && !sck_o)       falls <= falls + 1'b1;
      end
   end

   AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sck_o); // R1
   AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o != prev_sck) |-> (since == HALF_V)); // R2
   AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (lo_run == FRAME_V)); // R3
   AST_FALL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (falls == FALLS_V)); // R3
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R5
   AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $rose(cs_n_o)); // R5
   AST_RESULT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> valid_o); // R5
   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_err_o |-> ($rose(cs_n_o) && !valid_o)); // R6
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_run >= GAP_V)); // R7

endmodule

bind sadc_capture sadc_capture_chk #(
   .DIV_HALF (DIV_HALF),
   .RES_BITS (RES_BITS),
   .GAP_SCK  (GAP_SCK)
) i_sadc_capture_chk (.*);

// File: tb/test_sadc_capture.sv
module test_sadc_capture;

   localparam int N         = 8;
   localparam int D         = 8;
   localparam int GAPS      = 2;
   localparam int FRAME_CYC = (2 * N + 7) * D;
   localparam int GAP_CYC   = 2 * GAPS * D + 1;
   localparam int PERIOD    = FRAME_CYC + GAP_CYC;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         free_run_i = 1'b0;
   logic         sdo_i = 1'b1;
   logic         cs_n_o;
   logic         sck_o;
   logic [N-1:0] result_o;
   logic         valid_o;
   logic         pre_err_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   sadc_capture #(
      .SYS_CLK_HZ (50_000_000),
      .DIV_HALF   (D),
      .RES_BITS   (N),
      .GAP_SCK    (GAPS)
   ) i_sadc_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .free_run_i (free_run_i),
      .sdo_i      (sdo_i),
      .cs_n_o     (cs_n_o),
      .sck_o      (sck_o),
      .result_o   (result_o),
      .valid_o    (valid_o),
      .pre_err_o  (pre_err_o)
   );

   // converter model: leading bits from m_lead, then m_code MSB first
   logic [N-1:0] m_code = '0;
   logic [3:0]   m_lead = 4'b0000;
   int           m_falls = 0;

   always @(negedge cs_n_o or negedge sck_o or posedge cs_n_o) begin
      if (cs_n_o) begin
         sdo_i = 1'b1;
      end else if (sck_o) begin
         m_falls = 0;
         sdo_i = m_lead[0];
      end else begin
         m_falls++;
         if (m_falls <= 3) sdo_i = m_lead[m_falls];
         else if (m_falls - 4 < N) sdo_i = m_code[N - 1 - (m_falls - 4)];
         else sdo_i = 1'b0;
      end
   end

   // port monitor
   int   since = 0, lo_run = 0, hi_run = 100000, falls = 0;
   int   last_lo = 0, last_falls = 0, last_gap = 0, per_cnt = 0, last_per = 0;
   int   hp_min = 0, hp_max = 0, n_frames = 0;
   int   viol_idle = 0, viol_vwidth = 0, viol_vrise = 0;
   logic p_cs = 1'b1, p_sck = 1'b1, p_valid = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         per_cnt++;
         if (!cs_n_o && p_cs) begin
            last_gap = hi_run; last_per = per_cnt; per_cnt = 0;
            lo_run = 0; falls = 0; hp_min = 100000; hp_max = 0; n_frames++;
         end
         if (cs_n_o && !p_cs) begin
            last_lo = lo_run; last_falls = falls; hi_run = 0;
         end
         if (cs_n_o) hi_run++; else lo_run++;
         if (!cs_n_o && p_sck && !sck_o) falls++;
         if ((cs_n_o != p_cs) || (sck_o != p_sck)) begin
            if (!(!cs_n_o && p_cs)) begin
               if (since < hp_min) hp_min = since;
               if (since > hp_max) hp_max = since;
            end
            since = 1;
         end else begin
            since++;
         end
         if (cs_n_o && !sck_o) viol_idle++;
         if (valid_o && p_valid) viol_vwidth++;
         if ((valid_o || pre_err_o) && !(cs_n_o && !p_cs)) viol_vrise++;
         p_cs = cs_n_o; p_sck = sck_o; p_valid = valid_o;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic run_frame(input logic [N-1:0] code, input logic [3:0] lead,
                            output bit cs_next, output bit got_v, output bit got_e,
                            output logic [N-1:0] res);
      m_code = code;
      m_lead = lead;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      cs_next = !cs_n_o;
      got_v = 1'b0;
      got_e = 1'b0;
      res = result_o;
      for (int i = 0; i < 2000 && !got_v && !got_e; i++) begin
         @(negedge clk);
         got_v = valid_o;
         got_e = pre_err_o;
         res = result_o;
      end
      repeat (GAP_CYC + 2) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: actual %0d cycles expected completion", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit           csn, gv, ge;
      logic [N-1:0] r;
      int           f0;

      repeat (3) @(negedge clk);
      // reset state
      check(cs_n_o === 1'b1, "R1 reset cs_n", int'(cs_n_o), 1);
      check(sck_o === 1'b1, "R1 reset sck", int'(sck_o), 1);
      check(valid_o === 1'b0 && pre_err_o === 1'b0, "R5 reset strobes",
            int'({valid_o, pre_err_o}), 0);
      check(result_o === '0, "R5 reset result", int'(result_o), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(cs_n_o === 1'b1, "R10 no frame without request", int'(cs_n_o), 1);

      // exhaustive code sweep
      for (int c = 0; c < (1 << N); c++) begin
         run_frame(N'(c), 4'b0000, csn, gv, ge, r);
         check(csn, "R10 cs low after start", int'(csn), 1);
         check(gv && !ge, "R5 valid on good frame", int'({gv, ge}), 2);
         check(r == N'(c), "R4 result code", int'(r), c);
         if (c == 0 || c == (1 << N) - 1)
            check(r == N'(c), "R11 end-of-range code", int'(r), c);
         check(last_lo == FRAME_CYC, "R3 cs low length", last_lo, FRAME_CYC);
         check(last_falls == N + 3, "R3 falling edges", last_falls, N + 3);
         check(hp_min == D && hp_max == D, "R2 half period", hp_max * 1000 + hp_min,
               D * 1000 + D);
      end

      // leading-bit errors, each position, then all ones
      for (int p = 0; p < 5; p++) begin
         run_frame(N'(8'hA5), (p < 4) ? 4'(1 << p) : 4'hF, csn, gv, ge, r);
         check(ge && !gv, "R6 error instead of valid", int'({gv, ge}), 1);
         check(r == N'((1 << N) - 1), "R6 result kept", int'(r), (1 << N) - 1);
      end
      run_frame(N'(8'h3C), 4'b0000, csn, gv, ge, r);
      check(gv && r == N'(8'h3C), "R6 recovery after error", int'(r), 'h3C);

      // requests during a frame are held, several collapse into one
      m_code = N'(8'h5A);
      f0 = n_frames;
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      repeat (10) @(negedge clk);
      pulse_start();
      pulse_start();
      repeat (2 * PERIOD + 100) @(negedge clk);
      check(n_frames - f0 == 2, "R8 held request frame count", n_frames - f0, 2);
      check(last_gap == GAP_CYC, "R7 gap after held request", last_gap, GAP_CYC);
      check(result_o == N'(8'h5A), "R8 held frame result", int'(result_o), 'h5A);

      // request during the quiet time
      f0 = n_frames;
      pulse_start();
      for (int i = 0; i < 1000 && cs_n_o == 1'b1; i++) @(negedge clk);
      for (int i = 0; i < 1000 && cs_n_o == 1'b0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      pulse_start();
      repeat (2 * PERIOD + 100) @(negedge clk);
      check(n_frames - f0 == 2, "R8 request in gap frame count", n_frames - f0, 2);
      check(last_gap == GAP_CYC, "R7 gap after gap request", last_gap, GAP_CYC);

      // free-running frames
      m_code = N'(8'hC3);
      f0 = n_frames;
      @(negedge clk) free_run_i = 1'b1;
      for (int i = 0; i < 5 * PERIOD && n_frames - f0 < 4; i++) @(negedge clk);
      free_run_i = 1'b0;
      repeat (5) @(negedge clk);
      check(last_per == PERIOD, "R9 free-run period", last_per, PERIOD);
      check(last_gap == GAP_CYC, "R7 free-run gap", last_gap, GAP_CYC);
      repeat (2 * PERIOD) @(negedge clk);
      f0 = n_frames;
      repeat (2 * PERIOD) @(negedge clk);
      check(n_frames == f0, "R9 stops when released", n_frames - f0, 0);
      check(result_o == N'(8'hC3), "R9 free-run result", int'(result_o), 'hC3);

      // whole-run monitor results
      check(viol_idle == 0, "R1 sck low while deselected", viol_idle, 0);
      check(viol_vwidth == 0, "R5 strobe wider than one cycle", viol_vwidth, 0);
      check(viol_vrise == 0, "R5 strobe away from cs rise", viol_vrise, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule